// File: doc/BRIEF.md
# Scalar Branch and Program Counter Unit

This unit resolves the control-flow operations of one wavefront and produces the wavefront's next program counter. Each cycle it can accept one operation. The operation carries the current byte-addressed PC, an opcode, a signed 16-bit dword offset, the scalar condition flag, the 64-lane execute and condition masks, and a 64-bit value read from a scalar register pair. One cycle later the unit presents the next PC and a flag that says whether the PC was redirected.

Conditional operations test either the scalar flag or whether a lane mask is all zero. Two register-pair operations exist. The first loads the PC with an absolute address. The second exchanges the PC with the pair to implement call and return. For the exchange, the unit also presents the address of the following instruction, together with a write strobe, so that the surrounding logic can store it back into the pair.

Top module: `scalar_branch_unit`

## Requirements
- R1: While reset is asserted, and after it until the first accepted operation, out_valid, out_taken, out_ret_we, out_next_pc and out_ret_addr are all zero.
- R2: An operation presented with in_valid high produces its result on the outputs exactly one clock later, with out_valid high for that one cycle. Back-to-back operations produce back-to-back results.
- R3: Opcode 0 (unconditional jump) always sets out_taken to 1 and gives next PC = PC + 4 + sign_extend(imm) * 4.
- R4: Opcode 1 is taken when in_scc is 0, and opcode 2 is taken when in_scc is 1.
- R5: Opcode 3 is taken when all 64 bits of in_exec are zero, and opcode 4 is taken when any bit is set. Lane 0 and lane 63 count like any other lane.
- R6: Opcode 5 is taken when all 64 bits of in_vcc are zero, and opcode 6 is taken when any bit is set.
- R7: A conditional opcode whose condition fails gives out_taken = 0 and next PC = PC + 4.
- R8: The offset is signed. 0xFFFF yields the PC itself, 0x8000 yields PC + 4 - 131072, and the arithmetic wraps modulo 2^64.
- R9: Opcode 7 (load PC) gives next PC = in_sreg and out_taken = 1, with no write-back strobe.
- R10: Opcode 8 (swap PC) gives next PC = in_sreg and out_taken = 1. In the same cycle it gives out_ret_we = 1 and out_ret_addr = PC + 4.
- R11: Opcodes 9 to 15 are not control flow. They give out_taken = 0, next PC = PC + 4 and out_ret_we = 0.
- R12: In a cycle after in_valid was low, out_valid and out_ret_we are 0, and out_next_pc, out_taken and out_ret_addr keep their previous values whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_pc | input | 64 | Byte address of the operation |
| in_op | input | 4 | Branch opcode (encodings in R3 to R11) |
| in_imm | input | 16 | Signed dword offset |
| in_scc | input | 1 | Scalar condition flag |
| in_exec | input | 64 | Execute mask, one bit per lane |
| in_vcc | input | 64 | Vector condition mask, one bit per lane |
| in_sreg | input | 64 | Scalar register pair value |
| out_valid | output | 1 | Result present |
| out_next_pc | output | 64 | Next program counter |
| out_taken | output | 1 | PC redirected away from PC + 4 |
| out_ret_we | output | 1 | Write-back strobe for the register pair |
| out_ret_addr | output | 64 | Return address to write into the pair |

## Verification
The swap operation redirects the PC and produces a register-pair write-back in the same result cycle. An error in either path is easy to hide behind the other. The bench issues swaps whose register value differs from PC + 4, places them back-to-back with jumps and idle cycles, and compares target, taken flag, strobe and return address together against a behavioural model on every clock. A second overlap comes from mask tests that depend only on the highest or lowest lane. These are provoked with single-bit masks at lanes 0 and 63, and the taken flag and target are judged in the same compare.

// File: rtl/bru_pkg.sv
package bru_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    BR_JUMP      = 4'd0,
    BR_SCC_CLR   = 4'd1,
    BR_SCC_SET   = 4'd2,
    BR_EXEC_NONE = 4'd3,
    BR_EXEC_ANY  = 4'd4,
    BR_VCC_NONE  = 4'd5,
    BR_VCC_ANY   = 4'd6,
    BR_LOAD_PC   = 4'd7,
    BR_SWAP_PC   = 4'd8
  } br_op_e;

  typedef struct packed {
    logic redirect;  // PC leaves the sequential path
    logic from_reg;  // target comes from the register pair
    logic link;      // return address is written back
  } br_ctl_t;

endpackage

// File: rtl/bru_lane_any.sv
module bru_lane_any #(
  parameter int unsigned LANES = 64,
  parameter int unsigned GRP   = 8
) (
  input  logic [LANES-1:0] mask,
  output logic             any
);
  localparam int unsigned NGRP = (LANES + GRP - 1) / GRP;

  logic [NGRP-1:0] grp_or;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int unsigned LO = g * GRP;
    localparam int unsigned HI = (LO + GRP > LANES) ? (LANES - 1) : (LO + GRP - 1);
    assign grp_or[g] = |mask[HI:LO];
  end

  assign any = |grp_or;

endmodule

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            scc,
  input  logic            exec_any,
  input  logic            vcc_any,
  output br_ctl_t         ctl
);
  always_comb begin
    ctl = '0;
    case (op)
      BR_JUMP:      ctl.redirect = 1'b1;
      BR_SCC_CLR:   ctl.redirect = ~scc;
      BR_SCC_SET:   ctl.redirect = scc;
      BR_EXEC_NONE: ctl.redirect = ~exec_any;
      BR_EXEC_ANY:  ctl.redirect = exec_any;
      BR_VCC_NONE:  ctl.redirect = ~vcc_any;
      BR_VCC_ANY:   ctl.redirect = vcc_any;
      BR_LOAD_PC: begin
        ctl.redirect = 1'b1;
        ctl.from_reg = 1'b1;
      end
      BR_SWAP_PC: begin
        ctl.redirect = 1'b1;
        ctl.from_reg = 1'b1;
        ctl.link     = 1'b1;
      end
      default:      ctl = '0;
    endcase
  end

endmodule

// File: rtl/bru_target.sv
module bru_target #(
  parameter int unsigned PC_W        = 64,
  parameter int unsigned IMM_W       = 16,
  parameter int unsigned INSTR_BYTES = 4
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [IMM_W-1:0] imm,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  rel_pc
);
  localparam int unsigned SH    = $clog2(INSTR_BYTES);
  localparam int unsigned EXT_W = PC_W - IMM_W - SH;

  logic [PC_W-1:0] byte_ofs;

  assign byte_ofs = {{EXT_W{imm[IMM_W-1]}}, imm, {SH{1'b0}}};
  assign seq_pc   = pc + PC_W'(INSTR_BYTES);
  assign rel_pc   = seq_pc + byte_ofs;

endmodule

// File: rtl/scalar_branch_unit.sv
module scalar_branch_unit
  import bru_pkg::*;
#(
  parameter int unsigned PC_W        = 64,
  parameter int unsigned IMM_W       = 16,
  parameter int unsigned LANES       = 64,
  parameter int unsigned LANE_GRP    = 8,
  parameter int unsigned INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [OP_W-1:0]   in_op,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic              in_scc,
  input  logic [LANES-1:0]  in_exec,
  input  logic [LANES-1:0]  in_vcc,
  input  logic [PC_W-1:0]   in_sreg,
  output logic              out_valid,
  output logic [PC_W-1:0]   out_next_pc,
  output logic              out_taken,
  output logic              out_ret_we,
  output logic [PC_W-1:0]   out_ret_addr
);
  logic            exec_any, vcc_any;
  br_ctl_t         ctl;
  logic [PC_W-1:0] seq_pc, rel_pc, tgt_pc;

  bru_lane_any #(.LANES(LANES), .GRP(LANE_GRP)) u_exec_any (
    .mask (in_exec),
    .any  (exec_any)
  );

  bru_lane_any #(.LANES(LANES), .GRP(LANE_GRP)) u_vcc_any (
    .mask (in_vcc),
    .any  (vcc_any)
  );

  bru_decode u_dec (
    .op       (in_op),
    .scc      (in_scc),
    .exec_any (exec_any),
    .vcc_any  (vcc_any),
    .ctl      (ctl)
  );

  bru_target #(.PC_W(PC_W), .IMM_W(IMM_W), .INSTR_BYTES(INSTR_BYTES)) u_tgt (
    .pc     (in_pc),
    .imm    (in_imm),
    .seq_pc (seq_pc),
    .rel_pc (rel_pc)
  );

  always_comb begin
    if (ctl.from_reg)      tgt_pc = in_sreg;
    else if (ctl.redirect) tgt_pc = rel_pc;
    else                   tgt_pc = seq_pc;
  end

  // next-state
  logic            valid_d, taken_d, we_d;
  logic [PC_W-1:0] pc_d, ret_d;
  logic            data_en;

  assign data_en = in_valid;

  always_comb begin
    valid_d = in_valid;
    we_d    = in_valid & ctl.link;
    taken_d = out_taken;
    pc_d    = out_next_pc;
    ret_d   = out_ret_addr;
    if (data_en) begin
      taken_d = ctl.redirect;
      pc_d    = tgt_pc;
      ret_d   = seq_pc;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_taken    <= 1'b0;
      out_ret_we   <= 1'b0;
      out_next_pc  <= '0;
      out_ret_addr <= '0;
    end else begin
      out_valid    <= valid_d;
      out_taken    <= taken_d;
      out_ret_we   <= we_d;
      out_next_pc  <= pc_d;
      out_ret_addr <= ret_d;
    end
  end

  // assertions
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_ret_we && $stable(out_next_pc) && $stable(out_taken)));

  a_r10_strobe_only_on_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    out_ret_we |-> (out_valid && out_taken));

  a_r10_swap_result: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == BR_SWAP_PC) |=>
      (out_ret_we && out_next_pc == $past(in_sreg) &&
       out_ret_addr == $past(in_pc) + PC_W'(INSTR_BYTES)));

  a_r9_load_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == BR_LOAD_PC) |=> (!out_ret_we && out_next_pc == $past(in_sreg)));

  a_r5_exec_none_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == BR_EXEC_NONE && in_exec == '0) |=> out_taken);

  a_r7_fallthrough_seq: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_taken || out_next_pc == $past(in_pc) + PC_W'(INSTR_BYTES)));

  a_r3_jump_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == BR_JUMP) |=> out_taken);

endmodule

// File: tb/sim_scalar_branch_unit.sv
module sim_scalar_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_pc;
  logic [3:0]  in_op;
  logic [15:0] in_imm;
  logic        in_scc;
  logic [63:0] in_exec, in_vcc, in_sreg;
  logic        out_valid, out_taken, out_ret_we;
  logic [63:0] out_next_pc, out_ret_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // expected state
  logic        e_valid = 0, e_taken = 0, e_we = 0;
  logic [63:0] e_pc = 0, e_ret = 0;

  always #5 clk = ~clk;

  scalar_branch_unit u0 (
    .clk, .rst_n, .in_valid, .in_pc, .in_op, .in_imm, .in_scc,
    .in_exec, .in_vcc, .in_sreg,
    .out_valid, .out_next_pc, .out_taken, .out_ret_we, .out_ret_addr
  );

  task automatic compare(string tag);
    checks++;
    if (out_valid !== e_valid || out_taken !== e_taken || out_ret_we !== e_we ||
        out_next_pc !== e_pc || out_ret_addr !== e_ret) begin
      fails++;
      $display("FAIL %s: got v=%b t=%b we=%b pc=%h ret=%h exp v=%b t=%b we=%b pc=%h ret=%h",
               tag, out_valid, out_taken, out_ret_we, out_next_pc, out_ret_addr,
               e_valid, e_taken, e_we, e_pc, e_ret);
    end
  endtask

  task automatic step(input bit v, input logic [63:0] pc, input int op,
                      input logic [15:0] imm, input bit scc,
                      input logic [63:0] ex, input logic [63:0] vc,
                      input logic [63:0] sr, input string tag);
    longint signed ofs;
    bit take;
    @(negedge clk);
    in_valid = v; in_pc = pc; in_op = 4'(op); in_imm = imm; in_scc = scc;
    in_exec = ex; in_vcc = vc; in_sreg = sr;
    e_valid = v;
    e_we    = 1'b0;
    if (v) begin
      ofs  = longint'(shortint'(imm)) * 4;
      take = 1'b0;
      case (op)
        0: take = 1;
        1: take = (scc == 0);
        2: take = (scc == 1);
        3: take = (ex == 0);
        4: take = (ex != 0);
        5: take = (vc == 0);
        6: take = (vc != 0);
        7, 8: take = 1;
        default: take = 0;
      endcase
      e_taken = take;
      e_ret   = pc + 64'd4;
      if (op == 7 || op == 8) e_pc = sr;
      else if (take)          e_pc = pc + 64'd4 + 64'(ofs);
      else                    e_pc = pc + 64'd4;
      e_we = (op == 8);
    end
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got running exp finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 0; in_pc = 0; in_op = 0; in_imm = 0; in_scc = 0;
    in_exec = 0; in_vcc = 0; in_sreg = 0;
    repeat (3) @(posedge clk);
    #1 compare("R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 compare("R1 after release");

    // R3 jump
    step(1, 64'h1000, 0, 16'd5, 0, 0, 0, 64'hDEAD, "R3 jump fwd");
    step(1, 64'h2000, 0, 16'd0, 1, 0, 0, 0, "R3 jump zero ofs");
    // R4 scalar flag
    step(1, 64'h3000, 1, 16'd8, 0, 0, 0, 0, "R4 scc clr taken");
    step(1, 64'h3000, 1, 16'd8, 1, 0, 0, 0, "R4 R7 scc clr fails");
    step(1, 64'h3100, 2, 16'd3, 1, 0, 0, 0, "R4 scc set taken");
    step(1, 64'h3100, 2, 16'd3, 0, 0, 0, 0, "R4 R7 scc set fails");
    // R5 exec lanes
    step(1, 64'h4000, 3, 16'd2, 0, 64'd0, 64'hFFFF, 0, "R5 exec none taken");
    step(1, 64'h4000, 3, 16'd2, 0, 64'h8000_0000_0000_0000, 0, 0, "R5 exec lane63 blocks");
    step(1, 64'h4000, 4, 16'd2, 0, 64'h8000_0000_0000_0000, 0, 0, "R5 exec any lane63");
    step(1, 64'h4000, 4, 16'd2, 0, 64'd1, 0, 0, "R5 exec any lane0");
    step(1, 64'h4000, 4, 16'd2, 0, 64'd0, 64'hF, 0, "R5 R7 exec any fails");
    // R6 vcc lanes
    step(1, 64'h5000, 5, 16'd9, 0, 64'hF, 64'd0, 0, "R6 vcc none taken");
    step(1, 64'h5000, 5, 16'd9, 0, 0, 64'h0000_0100_0000_0000, 0, "R6 R7 vcc none fails");
    step(1, 64'h5000, 6, 16'd9, 0, 0, 64'h8000_0000_0000_0000, 0, "R6 vcc any lane63");
    step(1, 64'h5000, 6, 16'd9, 0, 64'hFF, 64'd0, 0, "R6 R7 vcc any fails");
    // R8 signed offsets
    step(1, 64'h6000, 0, 16'hFFFF, 0, 0, 0, 0, "R8 ofs -1");
    step(1, 64'h40000, 0, 16'h8000, 0, 0, 0, 0, "R8 ofs min");
    step(1, 64'h0, 0, 16'hFFFE, 0, 0, 0, 0, "R8 wrap below zero");
    step(1, 64'hFFFF_FFFF_FFFF_FFFC, 0, 16'h0001, 0, 0, 0, 0, "R8 wrap above top");
    // R9 load pc
    step(1, 64'h7000, 7, 16'h1234, 0, 0, 0, 64'hABCD_0000_1111_2220, "R9 load pc");
    // R10 swap, back to back with jump and idle
    step(1, 64'h8000, 8, 16'h0010, 0, 0, 0, 64'h0000_0000_0009_0000, "R10 swap");
    step(1, 64'h9000, 8, 16'h0000, 1, 1, 1, 64'h8004, "R10 swap return");
    step(1, 64'hA000, 0, 16'h0004, 0, 0, 0, 64'h1, "R2 R10 strobe drops");
    step(1, 64'hB000, 8, 16'h0000, 0, 0, 0, 64'hC0DE, "R10 swap before idle");
    // R12 idle with garbage
    step(0, 64'hFFFF, 8, 16'h7777, 1, 64'hFF, 64'hFF, 64'h1234, "R12 idle after swap");
    step(0, 64'h1, 0, 16'h1, 0, 0, 0, 0, "R12 idle hold");
    // R11 other opcodes
    for (int op = 9; op < 16; op++)
      step(1, 64'hC000 + 64'(op * 16), op, 16'h0040, 1, 64'hF, 64'hF, 64'h5555, "R11 non-branch op");
    // R2 mixed stream
    for (int i = 0; i < 300; i++) begin
      logic [63:0] ex, vc;
      ex = ($urandom % 3 == 0) ? 64'd0 : (64'd1 << ($urandom % 64));
      vc = ($urandom % 3 == 0) ? 64'd0 : {$urandom, $urandom};
      step(($urandom % 5) != 0, {$urandom, $urandom}, int'($urandom % 16),
           16'($urandom), 1'($urandom), ex, vc, {$urandom, $urandom}, "R2 mixed stream");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule